// File: doc/BRIEF.md
# Multi-Lane Serial Shift Engine

This block moves bytes between two byte streams and a set of up to four serial data lines for a serial-peripheral master. Software-visible control (lane width, byte count, run enable, a soft reset and a hold-select flag) arrives as plain inputs. An external timing block supplies shift strobes and runs the serial clock only while the engine asks for it. Each byte is taken from the transmit stream and shifted out most significant bits first. The bits captured on the same strobes are assembled into a byte and pushed to the receive stream. Both directions move the same number of bytes.

A transfer starts when the engine is idle and the enable input is high. The engine requests the serial clock only while a byte is loaded and shifting. If no transmit byte is ready, it pauses the clock instead of sending stale data. When the last byte has been sampled it raises a single-cycle completion pulse. It then waits for enable to drop before it accepts a new transfer. With the hold-select flag set, the select line stays asserted after completion, so the next transfer continues the same framed exchange.

Top module: `mlspi_engine`

## Requirements
- R1: After reset `sel_o`, `clk_en_o`, `tx_ready_o`, `rx_valid_o`, `done_o`, `dq_o` and `dq_oe_o` are all zero.
- R2: `mode_i` is latched at transfer start. Code 0 is one lane: bit 7 goes out first on `dq_o[0]`, input is sampled from `dq_i[1]`, and `dq_oe_o`=0001. Code 1 is two lanes: the higher bit of each pair is on `dq_o[1]`, input is sampled from `dq_i[1:0]`, and `dq_oe_o`=0011. Code 2 is four lanes: `dq_o[3:0]` carries the upper nibble first, input is sampled from `dq_i[3:0]`, and `dq_oe_o`=1111. Codes 3 to 7 behave as code 0. `dq_oe_o` is set while a transfer is active, and `dq_o` is nonzero only while shifting.
- R3: A transfer with count N pops exactly N bytes from the transmit stream (`tx_ready_o` high with `tx_valid_i`) and pushes exactly N bytes to the receive stream.
- R4: Each byte takes 8, 4 or 2 accepted strobes for one, two or four lanes. A strobe is accepted only while `clk_en_o` is high.
- R5: While a byte is needed and `tx_valid_i` is low, `clk_en_o` stays low, `sel_o` stays high, and strobes are ignored.
- R6: `done_o` is a one-cycle pulse in the cycle after the final accepted strobe. The engine then holds until `enable_i` goes low.
- R7: A count of zero gives a `done_o` pulse one cycle after start, without raising `clk_en_o` and without popping a byte.
- R8: When `enable_i` is low at a clock edge, the engine returns to idle. After an edge in which an active transfer was cut short, `clk_en_o` and `sel_o` are low.
- R9: When `soft_rst_i` is high at a clock edge, the engine returns to idle and releases any held select.
- R10: If `keep_sel_i` was high at start, `sel_o` stays high after completion and after `enable_i` drops. A later transfer started with `keep_sel_i` low releases it when that transfer completes.
- R11: `rx_valid_o` pulses in the cycle after the final strobe of each byte, with `rx_data_o` holding the bits sampled for that byte, earliest first in the most significant position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run enable; low aborts or re-arms |
| soft_rst_i | input | 1 | Synchronous return to idle |
| keep_sel_i | input | 1 | Hold select after this transfer |
| mode_i | input | 3 | Lane mode code |
| len_i | input | LEN_W | Byte count of the transfer |
| tx_data_i | input | DATA_W | Transmit stream data |
| tx_valid_i | input | 1 | Transmit byte available |
| tx_ready_o | output | 1 | Transmit byte taken this cycle |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | Received byte valid pulse |
| shift_stb_i | input | 1 | Shift strobe from timing block |
| clk_en_o | output | 1 | Request to run the serial clock |
| sel_o | output | 1 | Peripheral select, active high |
| dq_o | output | 4 | Serial data out lanes |
| dq_oe_o | output | 4 | Per-lane output enable |
| dq_i | input | 4 | Serial data in lanes |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the engine with its default values: 8-bit bytes and a 16-bit count. With an 8-bit byte, the one-, two- and four-lane modes take 8, 4 and 2 strobes per byte, so strobe counts per transfer are easy to predict. The 16-bit count lets a 300-byte run push the remaining-byte counter past an 8-bit boundary. It also covers the single-byte and zero-byte ends, under gated transmit data and sparse strobes.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;
  localparam int NUM_LANES  = 4;
  localparam int NUM_WIDTHS = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_DONE} eng_state_e;

  typedef enum logic [2:0] {
    MODE_SINGLE = 3'd0,
    MODE_DUAL   = 3'd1,
    MODE_QUAD   = 3'd2
  } lane_mode_e;

  // log2 of the lane count; reserved codes fall back to one lane
  function automatic logic [1:0] width_sel(input logic [2:0] code);
    case (code)
      MODE_DUAL: return 2'd1;
      MODE_QUAD: return 2'd2;
      default:   return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mlspi_lanes.sv
module mlspi_lanes
  import mlspi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [1:0]           wsel_i,
  input  logic                 load_i,
  input  logic [DATA_W-1:0]    load_data_i,
  input  logic                 tick_i,
  input  logic                 drive_i,
  input  logic                 active_i,
  input  logic [NUM_LANES-1:0] dq_i,
  output logic [NUM_LANES-1:0] dq_o,
  output logic [NUM_LANES-1:0] dq_oe_o,
  output logic [DATA_W-1:0]    rx_data_o
);
  logic [DATA_W-1:0]    tx_sr, rx_sr;
  logic [DATA_W-1:0]    tx_nx [NUM_WIDTHS];
  logic [DATA_W-1:0]    rx_nx [NUM_WIDTHS];
  logic [NUM_LANES-1:0] out_v [NUM_WIDTHS];
  logic [NUM_LANES-1:0] msk_v [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int W = 1 << g;
    assign tx_nx[g] = tx_sr << W;
    if (W == 1) begin : g_one
      // one-lane receive comes in on lane 1
      assign rx_nx[g] = {rx_sr[DATA_W-2:0], dq_i[1]};
    end else begin : g_multi
      assign rx_nx[g] = {rx_sr[DATA_W-W-1:0], dq_i[W-1:0]};
    end
    assign out_v[g] = NUM_LANES'(tx_sr[DATA_W-1 -: W]);
    assign msk_v[g] = NUM_LANES'((1 << W) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (clr_i) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load_i)      tx_sr <= load_data_i;
      else if (tick_i) tx_sr <= tx_nx[wsel_i];
      if (tick_i)      rx_sr <= rx_nx[wsel_i];
    end
  end

  assign dq_o      = drive_i  ? out_v[wsel_i] : '0;
  assign dq_oe_o   = active_i ? msk_v[wsel_i] : '0;
  assign rx_data_o = rx_sr;

  p_oe_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o == 4'h0 || dq_oe_o == 4'h1 || dq_oe_o == 4'h3 || dq_oe_o == 4'hF);
  p_drive_in_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_o & ~dq_oe_o) == '0);
endmodule

// File: rtl/mlspi_count.sv
module mlspi_count #(
  parameter int LEN_W  = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              load_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              tick_i,
  output logic              step_last_o,
  output logic              len_last_o
);
  logic [STEP_W-1:0] step_q;
  logic [LEN_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      left_q <= '0;
    end else if (clr_i) begin
      step_q <= '0;
      left_q <= '0;
    end else begin
      if (start_i) left_q <= len_i;
      if (load_i) begin
        step_q <= steps_i;
      end else if (tick_i) begin
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) left_q <= left_q - 1'b1;
      end
    end
  end

  assign step_last_o = (step_q == STEP_W'(1));
  assign len_last_o  = (left_q == LEN_W'(1));

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (step_q != '0 && left_q != '0));
endmodule

// File: rtl/mlspi_engine.sv
module mlspi_engine
  import mlspi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              soft_rst_i,
  input  logic              keep_sel_i,
  input  logic [2:0]        mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              shift_stb_i,
  output logic              clk_en_o,
  output logic              sel_o,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  input  logic [3:0]        dq_i,
  output logic              done_o
);
  localparam int STEP_W = $clog2(DATA_W + 1);

  eng_state_e st_q, st_n;
  logic [1:0] wsel_q;
  logic       keep_q, held_q, held_n, done_q, rxv_q;
  logic       run, start, accept, tick, step_last, len_last, byte_end;

  assign run      = enable_i && !soft_rst_i;
  assign start    = run && st_q == ST_IDLE;
  assign accept   = run && st_q == ST_LOAD && tx_valid_i;
  assign tick     = run && st_q == ST_SHIFT && shift_stb_i;
  assign byte_end = tick && step_last;

  always_comb begin
    st_n   = st_q;
    held_n = held_q;
    if (soft_rst_i) begin
      st_n   = ST_IDLE;
      held_n = 1'b0;
    end else if (!enable_i) begin
      st_n = ST_IDLE;
      if (st_q == ST_LOAD || st_q == ST_SHIFT) held_n = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (len_i == '0) begin
            st_n   = ST_DONE;
            held_n = keep_sel_i;
          end else begin
            st_n = ST_LOAD;
          end
        end
        ST_LOAD:  if (tx_valid_i) st_n = ST_SHIFT;
        ST_SHIFT: begin
          if (byte_end) begin
            if (len_last) begin
              st_n   = ST_DONE;
              held_n = keep_q;
            end else begin
              st_n = ST_LOAD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wsel_q <= '0;
      keep_q <= 1'b0;
      held_q <= 1'b0;
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      held_q <= held_n;
      done_q <= (st_n == ST_DONE) && (st_q != ST_DONE);
      rxv_q  <= byte_end;
      if (start) begin
        wsel_q <= width_sel(mode_i);
        keep_q <= keep_sel_i;
      end
    end
  end

  mlspi_count #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst_i),
    .start_i     (start),
    .len_i       (len_i),
    .load_i      (accept),
    .steps_i     (STEP_W'(DATA_W >> wsel_q)),
    .tick_i      (tick),
    .step_last_o (step_last),
    .len_last_o  (len_last)
  );

  mlspi_lanes #(.DATA_W(DATA_W)) u_lanes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst_i),
    .wsel_i      (wsel_q),
    .load_i      (accept),
    .load_data_i (tx_data_i),
    .tick_i      (tick),
    .drive_i     (st_q == ST_SHIFT),
    .active_i    (st_q == ST_LOAD || st_q == ST_SHIFT),
    .dq_i        (dq_i),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .rx_data_o   (rx_data_o)
  );

  assign tx_ready_o = accept;
  assign clk_en_o   = (st_q == ST_SHIFT);
  assign sel_o      = (st_q == ST_LOAD) || (st_q == ST_SHIFT) || held_q;
  assign rx_valid_o = rxv_q;
  assign done_o     = done_q;

  p_clk_needs_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> sel_o);
  p_pop_not_shifting_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !clk_en_o);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_with_last_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(clk_en_o)) |-> rx_valid_o);
  p_abort_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !clk_en_o);
  p_soft_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !sel_o);
  p_rx_from_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(clk_en_o && shift_stb_i));
endmodule

// File: tb/mlspi_engine_tb.sv
`timescale 1ns/100ps
module mlspi_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        enable_i = 0, soft_rst_i = 0, keep_sel_i = 0;
  logic [2:0]  mode_i = 0;
  logic [15:0] len_i = 0;
  logic [7:0]  tx_data_i = 0;
  logic        tx_valid_i = 0, shift_stb_i = 0;
  logic [3:0]  dq_i = 0;
  logic        tx_ready_o, rx_valid_o, clk_en_o, sel_o, done_o;
  logic [7:0]  rx_data_o;
  logic [3:0]  dq_o, dq_oe_o;

  mlspi_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable_i), .soft_rst_i(soft_rst_i),
    .keep_sel_i(keep_sel_i), .mode_i(mode_i), .len_i(len_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .shift_stb_i(shift_stb_i),
    .clk_en_o(clk_en_o), .sel_o(sel_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .dq_i(dq_i), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // stimulus sources
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  q[$];
  bit stb_rand = 0, gate_rand = 0, will_pop = 0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (will_pop && q.size() > 0) void'(q.pop_front());
    dq_i        = lfsr[3:0];
    shift_stb_i = stb_rand ? lfsr[5] : 1'b1;
    tx_valid_i  = (q.size() > 0) && (!gate_rand || lfsr[7]);
    tx_data_i   = (q.size() > 0) ? q[0] : 8'h00;
  end

  // behavioural reference
  int ph = 0, left = 0, steps = 0, w = 1;
  bit held = 0, keep = 0, e_done = 0, e_rxv = 0;
  logic [7:0] cur = 0, mrx = 0, e_rxd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; held = 0; w = 1; cur = 0; mrx = 0; e_done = 0; e_rxv = 0;
    end else begin
      e_done = 0; e_rxv = 0;
      if (soft_rst_i) begin
        ph = 0; held = 0; cur = 0; mrx = 0;
      end else if (!enable_i) begin
        if (ph == 1 || ph == 2) held = 0;
        ph = 0;
      end else begin
        case (ph)
          0: begin
            w = (mode_i == 3'd1) ? 2 : (mode_i == 3'd2) ? 4 : 1;
            keep = keep_sel_i;
            if (len_i == 0) begin ph = 3; held = keep; e_done = 1; end
            else begin left = len_i; ph = 1; end
          end
          1: if (tx_valid_i) begin cur = tx_data_i; steps = 8 / w; ph = 2; end
          2: if (shift_stb_i) begin
            if (w == 1) mrx = {mrx[6:0], dq_i[1]};
            else mrx = 8'((int'(mrx) << w) | (int'(dq_i) & ((1 << w) - 1)));
            cur = 8'(int'(cur) << w);
            steps--;
            if (steps == 0) begin
              e_rxv = 1; e_rxd = mrx; left--;
              if (left == 0) begin ph = 3; held = keep; e_done = 1; end
              else ph = 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and observation counters
  int n_tick = 0, n_pop = 0, n_rx = 0, n_done = 0, n_clk = 0, n_stall = 0;
  always @(negedge clk) begin
    #1;
    begin
      logic [3:0] e_oe, e_dq;
      bit act;
      act  = (ph == 1 || ph == 2);
      e_oe = act ? 4'((1 << w) - 1) : 4'h0;
      e_dq = (ph != 2) ? 4'h0 : (w == 1) ? {3'b0, cur[7]} :
             (w == 2) ? {2'b0, cur[7:6]} : cur[7:4];
      chk(sel_o == (act || held), "R10 sel_o", sel_o, act || held);
      chk(clk_en_o == (ph == 2), "R5 clk_en_o", clk_en_o, ph == 2);
      chk(tx_ready_o == (ph == 1 && tx_valid_i && enable_i && !soft_rst_i), "R3 tx_ready_o",
          tx_ready_o, ph == 1 && tx_valid_i && enable_i && !soft_rst_i);
      chk(dq_oe_o == e_oe, "R2 dq_oe_o", dq_oe_o, e_oe);
      chk(dq_o == e_dq, "R2 dq_o", dq_o, e_dq);
      chk(done_o == e_done, "R6 done_o", done_o, e_done);
      chk(rx_valid_o == e_rxv, "R11 rx_valid_o", rx_valid_o, e_rxv);
      if (e_rxv) chk(rx_data_o == e_rxd, "R11 rx_data_o", rx_data_o, e_rxd);
    end
    will_pop = tx_ready_o;
    if (tx_ready_o) n_pop++;
    if (clk_en_o) n_clk++;
    if (clk_en_o && shift_stb_i && enable_i && !soft_rst_i) n_tick++;
    if (rx_valid_o) n_rx++;
    if (done_o) n_done++;
    if (sel_o && !clk_en_o && dq_oe_o != 0 && !tx_valid_i) n_stall++;
  end

  task automatic clear_counts();
    n_tick = 0; n_pop = 0; n_rx = 0; n_done = 0; n_clk = 0; n_stall = 0;
  endtask

  task automatic xfer(input logic [2:0] m, input int n, input bit k);
    @(negedge clk); #1.5;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
    clear_counts();
    @(negedge clk);
    mode_i = m; len_i = 16'(n); keep_sel_i = k; enable_i = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1.5;
      if (n_done != 0) break;
    end
    @(negedge clk); enable_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1.5;
    // R1 reset state
    chk(sel_o == 0 && clk_en_o == 0 && done_o == 0, "R1 ctrl outputs", {sel_o, clk_en_o, done_o}, 0);
    chk(dq_oe_o == 0 && dq_o == 0 && tx_ready_o == 0 && rx_valid_o == 0, "R1 data outputs",
        {dq_oe_o, dq_o, tx_ready_o, rx_valid_o}, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    // one lane, steady strobes
    xfer(3'd0, 3, 0);
    chk(n_pop == 3, "R3 single pops", n_pop, 3);
    chk(n_rx == 3, "R3 single pushes", n_rx, 3);
    chk(n_tick == 24, "R4 single strobes", n_tick, 24);
    chk(n_done == 1, "R6 one done pulse", n_done, 1);

    // two lanes, sparse strobes, gated transmit data
    stb_rand = 1; gate_rand = 1;
    xfer(3'd1, 4, 0);
    chk(n_tick == 16, "R4 dual strobes", n_tick, 16);
    chk(n_pop == 4, "R3 dual pops", n_pop, 4);
    chk(n_stall > 0, "R5 stall observed", n_stall, 1);

    // four lanes with hold-select
    xfer(3'd2, 5, 1);
    chk(n_tick == 10, "R4 quad strobes", n_tick, 10);
    chk(sel_o == 1, "R10 select held", sel_o, 1);

    // reserved code acts as one lane; releases held select
    xfer(3'd5, 2, 0);
    chk(n_tick == 16, "R2 reserved code one lane", n_tick, 16);
    chk(sel_o == 0, "R10 select released", sel_o, 0);

    // zero length
    xfer(3'd2, 0, 0);
    chk(n_done == 1, "R7 zero length done", n_done, 1);
    chk(n_clk == 0 && n_pop == 0, "R7 zero length quiet", {n_clk, n_pop}, 0);

    // abort by enable
    stb_rand = 0; gate_rand = 0;
    @(negedge clk); #1.5;
    for (int i = 0; i < 10; i++) q.push_back(8'($urandom));
    @(negedge clk); mode_i = 0; len_i = 10; keep_sel_i = 0; enable_i = 1;
    repeat (12) @(negedge clk);
    enable_i = 0;
    @(negedge clk); #1.5;
    chk(clk_en_o == 0 && sel_o == 0, "R8 abort idle", {clk_en_o, sel_o}, 0);
    q.delete();
    repeat (2) @(negedge clk);

    // soft reset: held select and mid-transfer
    xfer(3'd1, 1, 1);
    chk(sel_o == 1, "R10 held before soft reset", sel_o, 1);
    @(negedge clk); soft_rst_i = 1;
    @(negedge clk); #1.5;
    chk(sel_o == 0, "R9 soft reset drops held select", sel_o, 0);
    soft_rst_i = 0;
    @(negedge clk); #1.5;
    for (int i = 0; i < 6; i++) q.push_back(8'($urandom));
    @(negedge clk); mode_i = 2; len_i = 6; keep_sel_i = 1; enable_i = 1;
    repeat (5) @(negedge clk);
    soft_rst_i = 1;
    @(negedge clk); #1.5;
    chk(sel_o == 0 && clk_en_o == 0, "R9 soft reset mid transfer", {sel_o, clk_en_o}, 0);
    soft_rst_i = 0; enable_i = 0;
    @(negedge clk); #1.5;
    q.delete();
    repeat (2) @(negedge clk);

    // long transfer crossing 8-bit count boundary
    stb_rand = 1; gate_rand = 1;
    xfer(3'd1, 300, 0);
    chk(n_pop == 300, "R3 long pops", n_pop, 300);
    chk(n_rx == 300, "R3 long pushes", n_rx, 300);
    chk(n_done == 1, "R6 long done", n_done, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule